// File: doc/BRIEF.md
# DMA Read Request Splitter

This block takes one memory read command, given as a 64-bit start address and a byte count, and turns it into a series of read requests on a request port with valid/ready handshaking. The request size is capped by a selectable maximum transfer size of 64, 128 or 256 bytes. No request crosses an address boundary that is a multiple of that size, so every request stays inside one naturally aligned block. An optional split rule tightens this further. With the rule on, a request whose address is not 128-byte aligned never crosses a 64-byte boundary. Larger chunks therefore start only from 128-byte-aligned addresses.

The block also limits how many requests may be outstanding at once. It counts requests that have been issued but not yet completed, and it stops issuing while that count equals the configured limit. Each pulse on the completion input retires one outstanding request. A done pulse marks the end of the command: it comes one cycle after the completion that leaves nothing outstanding once all bytes have been requested. Only one command is handled at a time. The configuration word is captured when a command is accepted.

Top module: `dma_rd_splitter`

## Requirements
- R1: Configuration bits [3:0] give the outstanding-request limit. A value of 0 acts as 1, a value above 12 acts as 12, and the limit is captured when a command is accepted.
- R2: Configuration bits [9:8] select the maximum transfer size: 0 = 64, 1 = 128, 2 or 3 = 256 bytes. Every request length lies between 1 and that size.
- R3: No request crosses an address boundary that is a multiple of the selected maximum transfer size.
- R4: With configuration bit 10 set, a request whose address has bits [6:0] not all zero does not cross a 64-byte boundary. A 128-byte-aligned request still uses the full size rule of R3.
- R5: Requests are contiguous, start at the command address and cover exactly the command byte count. Each request takes the largest length R2 to R4 allow, so the final one may have any length, odd lengths included.
- R6: The outstanding count never exceeds the limit, and req_valid_o is low while the count equals it. An issue and a completion in the same cycle leave the count unchanged.
- R7: While req_valid_o is high and req_ready_i is low, the request stays valid with unchanged address and length in the next cycle.
- R8: done_o pulses for one cycle, one cycle after the completion that leaves no request outstanding once all bytes are requested. A zero-length command issues no request, and done_o pulses the cycle after it is accepted.
- R9: cmd_ready_o is high only when no command is in progress. After reset, cmd_ready_o is 1 and req_valid_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 11 | Configuration: [3:0] outstanding limit, [9:8] size code, [10] split rule |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high together with valid |
| cmd_addr_i | input | 64 | Command start byte address |
| cmd_len_i | input | 16 | Command byte count |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 64 | Read request byte address |
| req_len_o | output | 9 | Read request byte length |
| rsp_done_i | input | 1 | One outstanding request has completed |
| done_o | output | 1 | Command finished, one-cycle pulse |

## Verification
The two functions that can fall in the same cycle are issuing a request and retiring an outstanding one. The bench provokes this in a responder mode that raises rsp_done_i in every cycle where something is outstanding, while req_ready_i stays mostly high. In that mode both counter updates land together. The results are judged by a bench-side outstanding count, which must never exceed the clamped limit and must never see req_valid_o high at the limit, and by done_o arriving exactly one cycle after the final completion.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  localparam int unsigned CFG_W = 11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } split_st_e;
endpackage

// File: rtl/dma_split_cfg.sv
module dma_split_cfg
  import dma_split_pkg::*;
#(
  parameter int unsigned MAX_PEND = 12,
  parameter int unsigned N_SIZES  = 3,
  parameter int unsigned CNT_W    = 4
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] lim_o,
  output logic [1:0]       size_o,
  output logic             split_o
);
  logic [3:0] pend;
  logic [1:0] code;

  assign pend    = cfg_i[3:0];
  assign code    = cfg_i[9:8];
  assign split_o = cfg_i[10];

  always_comb begin
    if (pend == 4'd0)                     lim_o = CNT_W'(1);
    else if (int'(pend) > int'(MAX_PEND)) lim_o = CNT_W'(MAX_PEND);
    else                                  lim_o = CNT_W'(pend);
  end

  // size codes beyond the supported set select the largest size
  always_comb begin
    if (int'(code) >= int'(N_SIZES)) size_o = 2'(N_SIZES - 1);
    else                             size_o = code;
  end
endmodule

// File: rtl/dma_split_chunk.sv
module dma_split_chunk #(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BASE_LOG = 6,
  parameter int unsigned N_SIZES  = 3,
  parameter int unsigned CHUNK_W  = BASE_LOG + N_SIZES
) (
  input  logic [CHUNK_W-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [1:0]         size_i,
  input  logic               split_i,
  output logic [CHUNK_W-1:0] len_o
);
  logic [CHUNK_W-1:0] room [N_SIZES];
  logic [CHUNK_W-1:0] room_sel;
  logic [1:0]         sel;
  logic               narrow;

  // bytes left to the next boundary, one per candidate size
  for (genvar g = 0; g < N_SIZES; g++) begin : g_room
    localparam int unsigned LG = BASE_LOG + g;
    assign room[g] = CHUNK_W'(1 << LG) - CHUNK_W'(addr_lo_i[LG-1:0]);
  end

  assign narrow = split_i && (addr_lo_i[BASE_LOG:0] != '0);
  assign sel    = narrow ? 2'd0 : size_i;

  always_comb begin
    room_sel = room[0];
    for (int g = 1; g < N_SIZES; g++) begin
      if (sel == 2'(g)) room_sel = room[g];
    end
  end

  always_comb begin
    if (LEN_W'(room_sel) > rem_i) len_o = rem_i[CHUNK_W-1:0];
    else                          len_o = room_sel;
  end
endmodule

// File: rtl/dma_split_credit.sv
module dma_split_credit #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             issue_i,
  input  logic             rsp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             retire;

  assign retire = rsp_i && (cnt_q != '0);
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({issue_i, retire})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: count bounded by limit
  a_r6_cnt_le_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_i);

  // R6: issue and retire together leave the count alone
  a_r6_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && retire) |=> $stable(cnt_q));

  a_r6_no_issue_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !issue_i);
endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter
  import dma_split_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned MAX_PEND = 12,
  parameter int unsigned BASE_LOG = 6,
  parameter int unsigned N_SIZES  = 3,
  localparam int unsigned CNT_W   = $clog2(MAX_PEND + 1),
  localparam int unsigned CHUNK_W = BASE_LOG + N_SIZES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [CHUNK_W-1:0] req_len_o,
  input  logic               rsp_done_i,
  output logic               done_o
);
  split_st_e          state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [CNT_W-1:0]   lim_q;
  logic [1:0]         size_q;
  logic               split_q;
  logic               done_q;

  logic [CNT_W-1:0]   dec_lim;
  logic [1:0]         dec_size;
  logic               dec_split;
  logic [CHUNK_W-1:0] chunk_len;
  logic [CNT_W-1:0]   out_cnt;
  logic               full;
  logic               fire;
  logic               last_rsp;

  dma_split_cfg #(
    .MAX_PEND (MAX_PEND),
    .N_SIZES  (N_SIZES),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .cfg_i   (cfg_i),
    .lim_o   (dec_lim),
    .size_o  (dec_size),
    .split_o (dec_split)
  );

  dma_split_chunk #(
    .LEN_W    (LEN_W),
    .BASE_LOG (BASE_LOG),
    .N_SIZES  (N_SIZES),
    .CHUNK_W  (CHUNK_W)
  ) u_chunk (
    .addr_lo_i (addr_q[CHUNK_W-1:0]),
    .rem_i     (rem_q),
    .size_i    (size_q),
    .split_i   (split_q),
    .len_o     (chunk_len)
  );

  dma_split_credit #(
    .CNT_W (CNT_W)
  ) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lim_i   (lim_q),
    .issue_i (fire),
    .rsp_i   (rsp_done_i),
    .cnt_o   (out_cnt),
    .full_o  (full)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign req_valid_o = (state_q == ST_ISSUE) && !full;
  assign req_addr_o  = addr_q;
  assign req_len_o   = chunk_len;
  assign fire        = req_valid_o && req_ready_i;
  assign last_rsp    = (state_q == ST_DRAIN) && rsp_done_i && (out_cnt == CNT_W'(1));
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      lim_q   <= CNT_W'(1);
      size_q  <= '0;
      split_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            addr_q  <= cmd_addr_i;
            rem_q   <= cmd_len_i;
            lim_q   <= dec_lim;
            size_q  <= dec_size;
            split_q <= dec_split;
            if (cmd_len_i == '0) done_q  <= 1'b1;
            else                 state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (fire) begin
            addr_q <= addr_q + ADDR_W'(chunk_len);
            rem_q  <= rem_q - LEN_W'(chunk_len);
            if (rem_q == LEN_W'(chunk_len)) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (last_rsp) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checking helpers
  logic [CHUNK_W:0] xfer_max;
  logic [CHUNK_W:0] span_end;
  logic [CHUNK_W:0] span64_end;

  assign xfer_max   = (CHUNK_W+1)'(1) << (BASE_LOG + size_q);
  assign span_end   = (({1'b0, req_addr_o[CHUNK_W-1:0]}) & (xfer_max - (CHUNK_W+1)'(1)))
                    + (CHUNK_W+1)'(req_len_o);
  assign span64_end = (CHUNK_W+1)'(req_addr_o[BASE_LOG-1:0]) + (CHUNK_W+1)'(req_len_o);

  a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && ((CHUNK_W+1)'(req_len_o) <= xfer_max));

  a_r3_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> span_end <= xfer_max);

  a_r4_split_64: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && split_q && (req_addr_o[BASE_LOG:0] != '0))
      |-> span64_end <= (CHUNK_W+1)'(1 << BASE_LOG));

  a_r5_len_le_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> LEN_W'(req_len_o) <= rem_q);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i)
      |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

  a_r8_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(rsp_done_i)
               || $past(cmd_valid_i && cmd_ready_o && (cmd_len_i == '0))));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_idle_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o && !req_valid_o);
endmodule

// File: tb/dma_rd_splitter_tb_top.sv
module dma_rd_splitter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] cfg_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [63:0] cmd_addr_i = '0;
  logic [15:0] cmd_len_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [63:0] req_addr_o;
  logic [8:0]  req_len_o;
  logic        rsp_done_i = 1'b0;
  logic        done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  dma_rd_splitter dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_len_i   (cmd_len_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_len_o   (req_len_o),
    .rsp_done_i  (rsp_done_i),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [63:0] a, input int rem, input int code, input bit sp);
    int sz;
    int lim;
    int room;
    sz   = 64 << ((code > 2) ? 2 : code);
    lim  = (sp && (a[6:0] != 7'd0)) ? 64 : sz;
    room = lim - (int'(a[8:0]) % lim);
    return (rem < room) ? rem : room;
  endfunction

  task automatic run_cmd(input logic [63:0] addr, input int len, input int pend,
                         input int code, input bit sp, input int mode);
    int          plim;
    logic [63:0] ea;
    int          erem;
    int          outc;
    int          peak;
    int          nreq;
    int          lastrsp;
    bit          got_done;
    bit          pv, pr;
    logic [63:0] pa;
    int          pl;
    int          el;
    bit          rdy, rsp, fire;
    string       tag;
    plim = (pend == 0) ? 1 : ((pend > 12) ? 12 : pend);
    ea = addr; erem = len; outc = 0; peak = 0; nreq = 0;
    lastrsp = (len == 0) ? -1 : -1000;
    got_done = 0; pv = 0; pr = 0; pa = '0; pl = 0;

    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R9 idle ready", cmd_ready_o, 1);
    cfg_i       = {sp, 2'(code), 4'd0, 4'(pend)};
    cmd_addr_i  = addr;
    cmd_len_i   = 16'(len);
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cfg_i       = 11'h7ff; // captured config must not follow later changes (R1)

    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (done_o) begin
        chk(erem == 0 && outc == 0 && cyc == lastrsp + 1, "R8 done timing", cyc, lastrsp + 1);
        got_done = 1;
        break;
      end
      if (cyc == 0) chk(cmd_ready_o == 1'b0, "R9 busy", cmd_ready_o, 0);
      if (outc >= plim) chk(req_valid_o == 1'b0, "R6 stall at limit", req_valid_o, 0);
      if (erem == 0)    chk(req_valid_o == 1'b0, "R5 no extra request", req_valid_o, 0);
      if (pv && !pr)
        chk(req_valid_o && req_addr_o == pa && int'(req_len_o) == pl, "R7 hold",
            req_addr_o, pa);
      el = 0;
      if (req_valid_o) begin
        el  = exp_len(ea, erem, code, sp);
        tag = (sp && ea[6:0] != 7'd0) ? "R4 split length" : "R3 boundary length";
        chk(req_addr_o == ea, "R5 address", req_addr_o, ea);
        chk(int'(req_len_o) == el, tag, req_len_o, el);
      end
      unique case (mode)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 3) != 1;
        default: rdy = cyc[0];
      endcase
      unique case (mode)
        0:       rsp = (outc > 0) && !req_valid_o;
        1:       rsp = (outc > 0);
        default: rsp = (outc > 0) && (cyc % 2 == 0);
      endcase
      fire = req_valid_o && rdy;
      pv = req_valid_o; pr = rdy; pa = req_addr_o; pl = int'(req_len_o);
      req_ready_i = rdy;
      rsp_done_i  = rsp;
      @(posedge clk_i);
      if (fire) begin
        ea   = ea + 64'(el);
        erem = erem - el;
        outc++;
        nreq++;
      end
      if (rsp) outc--;
      if (outc > peak) peak = outc;
      if (rsp && outc == 0 && erem == 0) lastrsp = cyc;
      @(negedge clk_i);
      req_ready_i = 1'b0;
      rsp_done_i  = 1'b0;
    end
    chk(got_done, "R8 done seen", got_done, 1);
    chk(peak <= plim, "R6 peak within limit", peak, plim);
    if (mode == 0 && nreq >= plim) chk(peak == plim, "R1 clamped limit reached", peak, plim);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int offs [10] = '{0, 1, 32, 63, 64, 65, 127, 128, 192, 255};
    int lens [8]  = '{1, 3, 63, 64, 65, 129, 300, 700};
    int pends [5] = '{0, 1, 2, 12, 15};
    int idx;
    logic [63:0] base;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R9 reset ready", cmd_ready_o, 1);
    chk(req_valid_o == 1'b0, "R9 reset valid", req_valid_o, 0);
    chk(done_o == 1'b0, "R9 reset done", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_cmd(64'h1000, 0, 4, 1, 1'b0, 0); // R8 zero length
    run_cmd(64'h20, 96, 4, 1, 1'b0, 0);  // R3 without split: 96 then nothing
    run_cmd(64'h20, 96, 4, 1, 1'b1, 0);  // R4 with split: 32 then 64

    idx = 0;
    for (int code = 0; code < 4; code++) begin
      for (int sp = 0; sp < 2; sp++) begin
        for (int o = 0; o < 10; o++) begin
          for (int l = 0; l < 8; l++) begin
            base = (idx % 7 == 6) ? 64'hFFFF_FFFF_FFFF_FE00 : 64'(idx) << 9;
            run_cmd(base + 64'(offs[o]), lens[l], pends[idx % 5], code, sp[0], idx % 3);
            idx++;
          end
        end
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule